// File: doc/BRIEF.md
# Keyed Backup Real-Time Counter

This block is a free-running real-time counter that sits on a simple word-addressed register bus. A slow tick-enable input goes through a power-of-two prescaler and then advances a counter of `CNT_W` bits. A single compare register can clear the counter when it matches, which turns the counter into a periodic timer. The compare can also leave out a chosen number of low-order bits, so a match covers a whole window of counter values. Overflow and compare events are latched as interrupt flags. Software can set, clear and enable each flag, and the enabled flags are combined onto one interrupt line.

Software protects the timekeeping setup with a key register. Any value other than the key shuts the control, counter and compare registers against writes, and the key opens them again. A freeze register lets software stage several compare writes without the live comparator seeing values in between. Releasing the freeze applies the last staged value in one step.

Two small state machines govern the block. The lock machine has states `LK_OPEN` and `LK_SHUT`. A lock-register write carrying the key takes it to `LK_OPEN` (transition *unlock*). Any other lock-register write takes it to `LK_SHUT` (transition *lock*). The freeze machine has states `FZ_LIVE` and `FZ_HELD`. A freeze-register write with bit 0 set takes it to `FZ_HELD` (transition *hold*). A freeze-register write with bit 0 clear takes it back to `FZ_LIVE` (transition *release*), and *release* copies the staged compare value into the live comparator. Both machines stay in their state on any other cycle.

Top module: `rtc_keyed_timer`

## Requirements
- R1: After reset the registers read as follows: control 0x00000008, counter 0, compare 0, lock 0, flags 0, enable 0, freeze 0. The interrupt output is low.
- R2: A control write stores only the bits in mask 0x77FF. The fields are: run mode at bits 1:0, compare-clear at bit 4, ignored-LSB count at bits 7:5 and prescale code at bits 10:8.
- R3: When the run mode is non-zero, the counter advances once per 2^p ticks, where p is the prescale code (0 to 7). When the run mode is 0, the counter holds its value. Any accepted control or counter write restarts the prescale count.
- R4: With an ignored-LSB count of k, the compare looks only at bits above bit k-1 of both the counter and the compare value.
- R5: Flag bit 1 (compare) sets on the counting step on which the masked counter first becomes equal to the masked compare value. It does not set again while the two stay equal.
- R6: With compare-clear set, a counting step taken while the masked counter equals the masked compare value loads 0 instead of incrementing.
- R7: Flag bit 0 (overflow) sets when a counting step wraps the counter from all ones to 0.
- R8: Writing 1s to the flag-set register (0x2C) sets the matching flags. Writing 1s to the flag-clear register (0x30) clears them. Flag bit 2 is set only by software. The interrupt output is high when any flag is set together with its enable bit (0x34).
- R9: A lock write (0x24) of 0xAEE8 in bits 15:0 unlocks, and any other value locks. Lock reads return 1 when locked. While locked, writes to control (0x00), counter (0x08) and compare (0x0C) are ignored, while the enable and flag registers stay writable.
- R10: While freeze (0x38, bit 0) is set, compare writes are staged and compare reads keep returning the live value. Clearing freeze makes the last staged value live.
- R11: When a hardware flag event and a flag-clear write land in the same cycle, the flag ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | Low-frequency tick enable, one clock wide per tick |
| bus_en_i | input | 1 | Register access strobe |
| bus_we_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | 8 | Byte address; only exact word addresses decode |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, combinational from the address |
| irq_o | output | 1 | OR of enabled flags |

## Verification
Several rules are checked on every cycle. A disabled counter does not move unless it is loaded. The control register cannot change after a control write while locked. The live compare value cannot change while held except through a release. Each overflow or compare event is followed by its flag, and the interrupt never rises with all enables clear. Other behaviour only shows over a scenario, so the bench covers it with directed sequences. These cover the prescale ratio at several codes, the point at which a masked match fires and that it fires only once, the compare-clear period, the key decoding, staged compare values becoming live on release, and a clear write that collides with a compare event.

// File: rtl/rtc_pkg.sv
package rtc_pkg;

    localparam int unsigned BUS_W   = 32;
    localparam int unsigned ADDR_W  = 8;
    localparam int unsigned SEL_W   = 3;
    localparam int unsigned NFLAG   = 3;
    localparam int unsigned KEY_W   = 16;

    // Register word addresses (byte addressed, word aligned)
    localparam logic [ADDR_W-1:0] RA_CTRL = 8'h00;
    localparam logic [ADDR_W-1:0] RA_CNT  = 8'h08;
    localparam logic [ADDR_W-1:0] RA_CMP  = 8'h0C;
    localparam logic [ADDR_W-1:0] RA_LOCK = 8'h24;
    localparam logic [ADDR_W-1:0] RA_FLAG = 8'h28;
    localparam logic [ADDR_W-1:0] RA_FSET = 8'h2C;
    localparam logic [ADDR_W-1:0] RA_FCLR = 8'h30;
    localparam logic [ADDR_W-1:0] RA_IEN  = 8'h34;
    localparam logic [ADDR_W-1:0] RA_FRZ  = 8'h38;

    localparam logic [KEY_W-1:0] OPEN_KEY   = 16'hAEE8;
    localparam logic [BUS_W-1:0] CTRL_INIT  = 32'h0000_0008;
    localparam logic [BUS_W-1:0] CTRL_WMASK = 32'h0000_77FF;

    // Control field positions
    localparam int unsigned CF_RUN_LO  = 0;
    localparam int unsigned CF_TOP     = 4;
    localparam int unsigned CF_IGN_LO  = 5;
    localparam int unsigned CF_DIV_LO  = 8;

    // Flag bit positions
    localparam int unsigned FB_OVF = 0;
    localparam int unsigned FB_CMP = 1;
    localparam int unsigned FB_OSC = 2;

    typedef enum logic {LK_OPEN, LK_SHUT} lock_state_t;
    typedef enum logic {FZ_LIVE, FZ_HELD} frz_state_t;

endpackage

// File: rtl/rtc_tick_div.sv
module rtc_tick_div #(
    parameter int unsigned SEL_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             restart,
    input  logic             tick_i,
    input  logic [SEL_W-1:0] sel,
    output logic             pulse_o
);
    localparam int unsigned PW = (1 << SEL_W) - 1;

    logic [PW-1:0] acc_q;
    logic [PW-1:0] need;

    always_comb begin
        need    = (PW'(1) << sel) - PW'(1);
        pulse_o = run && tick_i && !restart && ((acc_q & need) == need);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_q <= '0;
        end else if (restart || !run) begin
            acc_q <= '0;
        end else if (tick_i) begin
            acc_q <= acc_q + PW'(1);
        end
    end
endmodule

// File: rtl/rtc_lock_fsm.sv
module rtc_lock_fsm
    import rtc_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_lock,
    input  logic [KEY_W-1:0] key,
    output logic             locked
);
    lock_state_t state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= LK_OPEN;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            LK_OPEN: if (wr_lock && key != OPEN_KEY) state_d = LK_SHUT;
            LK_SHUT: if (wr_lock && key == OPEN_KEY) state_d = LK_OPEN;
        endcase
    end

    always_comb begin
        locked = (state_q == LK_SHUT);
    end
endmodule

// File: rtl/rtc_freeze_fsm.sv
module rtc_freeze_fsm
    import rtc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic wr_frz,
    input  logic frz_bit,
    output logic held,
    output logic release_o
);
    frz_state_t state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= FZ_LIVE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            FZ_LIVE: if (wr_frz && frz_bit)  state_d = FZ_HELD;
            FZ_HELD: if (wr_frz && !frz_bit) state_d = FZ_LIVE;
        endcase
    end

    always_comb begin
        held      = (state_q == FZ_HELD);
        release_o = (state_q == FZ_HELD) && (state_d == FZ_LIVE);
    end
endmodule

// File: rtl/rtc_count_core.sv
module rtc_count_core #(
    parameter int unsigned CNT_W = 32,
    parameter int unsigned SEL_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step,
    input  logic             ld,
    input  logic [CNT_W-1:0] ld_val,
    input  logic [CNT_W-1:0] cmp_val,
    input  logic [SEL_W-1:0] ign,
    input  logic             top_clr,
    output logic [CNT_W-1:0] cnt_o,
    output logic             cmp_evt,
    output logic             ovf_evt
);
    localparam logic [CNT_W-1:0] ALL1 = '1;

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] keep;
    logic [CNT_W-1:0] inc;
    logic [CNT_W-1:0] step_val;
    logic             cur_hit;
    logic             wrap_top;
    logic             new_hit;

    always_comb begin
        keep     = ALL1 << ign;
        inc      = cnt_q + CNT_W'(1);
        cur_hit  = ((cnt_q ^ cmp_val) & keep) == '0;
        wrap_top = top_clr && cur_hit;
        step_val = wrap_top ? '0 : inc;
        new_hit  = (((step_val ^ cmp_val) & keep) == '0) && !cur_hit;
        cmp_evt  = step && !ld && new_hit;
        ovf_evt  = step && !ld && !wrap_top && (cnt_q == ALL1);
        cnt_o    = cnt_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    cnt_q <= '0;
        else if (ld)   cnt_q <= ld_val;
        else if (step) cnt_q <= step_val;
    end
endmodule

// File: rtl/rtc_keyed_timer.sv
module rtc_keyed_timer
    import rtc_pkg::*;
#(
    parameter int unsigned CNT_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_i,
    input  logic              bus_en_i,
    input  logic              bus_we_i,
    input  logic [ADDR_W-1:0] bus_addr_i,
    input  logic [BUS_W-1:0]  bus_wdata_i,
    output logic [BUS_W-1:0]  bus_rdata_o,
    output logic              irq_o
);
    logic [BUS_W-1:0] ctrl_q;
    logic [CNT_W-1:0] cmp_q;
    logic [CNT_W-1:0] cmp_stage_q;
    logic [NFLAG-1:0] flags_q;
    logic [NFLAG-1:0] ien_q;
    logic [CNT_W-1:0] cnt_q;

    logic wr, locked, held, release_pulse;
    logic wr_ctrl, wr_cnt, wr_cmp, wr_lock, wr_fset, wr_fclr, wr_ien, wr_frz;
    logic run, step, cmp_evt, ovf_evt;
    logic [NFLAG-1:0] hw_set, sw_set, sw_clr;

    always_comb begin
        wr      = bus_en_i && bus_we_i;
        wr_ctrl = wr && bus_addr_i == RA_CTRL && !locked;
        wr_cnt  = wr && bus_addr_i == RA_CNT  && !locked;
        wr_cmp  = wr && bus_addr_i == RA_CMP  && !locked;
        wr_lock = wr && bus_addr_i == RA_LOCK;
        wr_fset = wr && bus_addr_i == RA_FSET;
        wr_fclr = wr && bus_addr_i == RA_FCLR;
        wr_ien  = wr && bus_addr_i == RA_IEN;
        wr_frz  = wr && bus_addr_i == RA_FRZ;
        run     = ctrl_q[CF_RUN_LO +: 2] != 2'b00;
    end

    rtc_lock_fsm u_lock (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_lock (wr_lock),
        .key     (bus_wdata_i[KEY_W-1:0]),
        .locked  (locked)
    );

    rtc_freeze_fsm u_frz (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_frz    (wr_frz),
        .frz_bit   (bus_wdata_i[0]),
        .held      (held),
        .release_o (release_pulse)
    );

    rtc_tick_div #(.SEL_W(SEL_W)) u_div (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (run),
        .restart (wr_ctrl || wr_cnt),
        .tick_i  (tick_i),
        .sel     (ctrl_q[CF_DIV_LO +: SEL_W]),
        .pulse_o (step)
    );

    rtc_count_core #(.CNT_W(CNT_W), .SEL_W(SEL_W)) u_core (
        .clk     (clk),
        .rst_n   (rst_n),
        .step    (step),
        .ld      (wr_cnt),
        .ld_val  (bus_wdata_i[CNT_W-1:0]),
        .cmp_val (cmp_q),
        .ign     (ctrl_q[CF_IGN_LO +: SEL_W]),
        .top_clr (ctrl_q[CF_TOP]),
        .cnt_o   (cnt_q),
        .cmp_evt (cmp_evt),
        .ovf_evt (ovf_evt)
    );

    // Control register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       ctrl_q <= CTRL_INIT;
        else if (wr_ctrl) ctrl_q <= bus_wdata_i & CTRL_WMASK;
    end

    // Compare: staged copy always follows writes, live copy follows when not held
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cmp_stage_q <= '0;
            cmp_q       <= '0;
        end else begin
            if (wr_cmp) cmp_stage_q <= bus_wdata_i[CNT_W-1:0];
            if (wr_cmp && !held)    cmp_q <= bus_wdata_i[CNT_W-1:0];
            else if (release_pulse) cmp_q <= cmp_stage_q;
        end
    end

    // Flags: set sources win over clear
    always_comb begin
        hw_set          = '0;
        hw_set[FB_OVF]  = ovf_evt;
        hw_set[FB_CMP]  = cmp_evt;
        sw_set          = wr_fset ? bus_wdata_i[NFLAG-1:0] : '0;
        sw_clr          = wr_fclr ? bus_wdata_i[NFLAG-1:0] : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flags_q <= '0;
        else        flags_q <= (flags_q & ~sw_clr) | sw_set | hw_set;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      ien_q <= '0;
        else if (wr_ien) ien_q <= bus_wdata_i[NFLAG-1:0];
    end

    always_comb begin
        irq_o = |(flags_q & ien_q);
    end

    // Read mux
    always_comb begin
        bus_rdata_o = '0;
        case (bus_addr_i)
            RA_CTRL: bus_rdata_o = ctrl_q;
            RA_CNT:  bus_rdata_o = BUS_W'(cnt_q);
            RA_CMP:  bus_rdata_o = BUS_W'(cmp_q);
            RA_LOCK: bus_rdata_o = BUS_W'(locked);
            RA_FLAG: bus_rdata_o = BUS_W'(flags_q);
            RA_IEN:  bus_rdata_o = BUS_W'(ien_q);
            RA_FRZ:  bus_rdata_o = BUS_W'(held);
            default: bus_rdata_o = '0;
        endcase
    end
endmodule

// File: rtl/rtc_keyed_timer_chk.sv
module rtc_keyed_timer_chk
    import rtc_pkg::*;
#(
    parameter int unsigned CNT_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              locked,
    input logic              held,
    input logic [BUS_W-1:0]  ctrl_q,
    input logic [CNT_W-1:0]  cnt_q,
    input logic [CNT_W-1:0]  cmp_q,
    input logic [NFLAG-1:0]  flags_q,
    input logic [NFLAG-1:0]  ien_q,
    input logic              irq_o,
    input logic              bus_en_i,
    input logic              bus_we_i,
    input logic [ADDR_W-1:0] bus_addr_i,
    input logic              wbit0,
    input logic              wr_cnt,
    input logic              cmp_evt,
    input logic              ovf_evt
);
    a_r3_disabled_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_q[1:0] == 2'b00 && !wr_cnt) |=> $stable(cnt_q));

    a_r9_locked_ctrl: assert property (@(posedge clk) disable iff (!rst_n)
        (locked && bus_en_i && bus_we_i && bus_addr_i == RA_CTRL) |=> $stable(ctrl_q));

    a_r10_held_cmp: assert property (@(posedge clk) disable iff (!rst_n)
        (held && !(bus_en_i && bus_we_i && bus_addr_i == RA_FRZ && !wbit0)) |=> $stable(cmp_q));

    a_r7_overflow_flag: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_evt |=> (cnt_q == '0 && flags_q[FB_OVF]));

    a_r5_compare_flag: assert property (@(posedge clk) disable iff (!rst_n)
        cmp_evt |=> flags_q[FB_CMP]);

    a_r8_irq_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> (ien_q != '0));
endmodule

bind rtc_keyed_timer rtc_keyed_timer_chk #(.CNT_W(CNT_W)) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .locked     (locked),
    .held       (held),
    .ctrl_q     (ctrl_q),
    .cnt_q      (cnt_q),
    .cmp_q      (cmp_q),
    .flags_q    (flags_q),
    .ien_q      (ien_q),
    .irq_o      (irq_o),
    .bus_en_i   (bus_en_i),
    .bus_we_i   (bus_we_i),
    .bus_addr_i (bus_addr_i),
    .wbit0      (bus_wdata_i[0]),
    .wr_cnt     (wr_cnt),
    .cmp_evt    (cmp_evt),
    .ovf_evt    (ovf_evt)
);

// File: tb/rtc_keyed_timer_tb_top.sv
module rtc_keyed_timer_tb_top;
    import rtc_pkg::*;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_i = 1'b0;
    logic        bus_en = 1'b0;
    logic        bus_we = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    wire  [31:0] bus_rdata;
    wire         irq;

    int n_run = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    // Scoreboard queues: bit 32 marks an interrupt-line item
    logic [32:0] exp_q[$];
    string       tag_q[$];
    event        sample_ev;

    always #(CLK_PERIOD/2) clk = ~clk;

    rtc_keyed_timer dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .tick_i      (tick_i),
        .bus_en_i    (bus_en),
        .bus_we_i    (bus_we),
        .bus_addr_i  (bus_addr),
        .bus_wdata_i (bus_wdata),
        .bus_rdata_o (bus_rdata),
        .irq_o       (irq)
    );

    // Monitor
    initial begin
        forever begin
            @(sample_ev);
            if (exp_q.size() != 0) begin
                logic [32:0] e;
                logic [31:0] act;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                act = e[32] ? {31'b0, irq} : bus_rdata;
                n_run++;
                if (act !== e[31:0]) begin
                    n_fail++;
                    $display("FAIL %s: actual 0x%08h expected 0x%08h", t, act, e[31:0]);
                end
            end
        end
    end

    task automatic bus_wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_en = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d; tick_i = 1'b0;
    endtask

    task automatic bus_wr_tick(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_en = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d; tick_i = 1'b1;
    endtask

    task automatic chk_rd(input logic [7:0] a, input logic [31:0] e, input string t);
        @(negedge clk);
        bus_en = 1'b1; bus_we = 1'b0; bus_addr = a; tick_i = 1'b0;
        exp_q.push_back({1'b0, e});
        tag_q.push_back(t);
        #(CLK_PERIOD/4);
        -> sample_ev;
    endtask

    task automatic chk_irq(input logic e, input string t);
        @(negedge clk);
        bus_en = 1'b0; bus_we = 1'b0; tick_i = 1'b0;
        exp_q.push_back({1'b1, 31'b0, e});
        tag_q.push_back(t);
        #(CLK_PERIOD/4);
        -> sample_ev;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            bus_en = 1'b0; bus_we = 1'b0; tick_i = 1'b1;
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        n_run++;
        n_fail++;
        $display("FAIL watchdog (all requirements): actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset values
        chk_rd(RA_CTRL, 32'h8, "R1 ctrl");
        chk_rd(RA_CNT,  32'h0, "R1 cnt");
        chk_rd(RA_CMP,  32'h0, "R1 cmp");
        chk_rd(RA_LOCK, 32'h0, "R1 lock");
        chk_rd(RA_FLAG, 32'h0, "R1 flags");
        chk_rd(RA_IEN,  32'h0, "R1 ien");
        chk_rd(RA_FRZ,  32'h0, "R1 freeze");
        chk_irq(1'b0, "R1 irq");
        ticks(4);
        chk_rd(RA_CNT, 32'h0, "R3 disabled after reset");

        // R2 write mask
        bus_wr(RA_CTRL, 32'hFFFF_FFFF);
        chk_rd(RA_CTRL, 32'h77FF, "R2 mask");
        bus_wr(RA_CTRL, 32'h1);

        // R3 prescaler
        bus_wr(RA_CNT, 32'h0);
        ticks(10);
        chk_rd(RA_CNT, 32'd10, "R3 div1");
        bus_wr(RA_CTRL, 32'h201);
        bus_wr(RA_CNT, 32'h0);
        ticks(9);
        chk_rd(RA_CNT, 32'd2, "R3 div4");
        bus_wr(RA_CTRL, 32'h701);
        bus_wr(RA_CNT, 32'h0);
        ticks(384);
        chk_rd(RA_CNT, 32'd3, "R3 div128");
        ticks(127);
        chk_rd(RA_CNT, 32'd3, "R3 div128 partial");
        ticks(1);
        chk_rd(RA_CNT, 32'd4, "R3 div128 next");
        bus_wr(RA_CTRL, 32'h0);
        ticks(5);
        chk_rd(RA_CNT, 32'd4, "R3 disabled holds");

        // R5 compare flag
        bus_wr(RA_CTRL, 32'h1);
        bus_wr(RA_CMP, 32'd5);
        bus_wr(RA_CNT, 32'd0);
        ticks(4);
        chk_rd(RA_FLAG, 32'h0, "R5 before match");
        ticks(1);
        chk_rd(RA_CNT, 32'd5, "R5 count at match");
        chk_rd(RA_FLAG, 32'h2, "R5 match flag");
        bus_wr(RA_FCLR, 32'h2);
        ticks(3);
        chk_rd(RA_FLAG, 32'h0, "R5 no refire");

        // R4 ignored LSBs (k = 3)
        bus_wr(RA_CTRL, 32'h61);
        bus_wr(RA_CMP, 32'h23);
        bus_wr(RA_CNT, 32'h10);
        ticks(15);
        chk_rd(RA_FLAG, 32'h0, "R4 below window");
        ticks(1);
        chk_rd(RA_CNT, 32'h20, "R4 count at window");
        chk_rd(RA_FLAG, 32'h2, "R4 masked match");
        bus_wr(RA_FCLR, 32'h2);
        ticks(3);
        chk_rd(RA_FLAG, 32'h0, "R4 R5 inside window no refire");

        // R6 compare clears counter
        bus_wr(RA_FCLR, 32'h7);
        bus_wr(RA_CTRL, 32'h11);
        bus_wr(RA_CMP, 32'd3);
        bus_wr(RA_CNT, 32'd0);
        ticks(3);
        chk_rd(RA_CNT, 32'd3, "R6 reach top");
        chk_rd(RA_FLAG, 32'h2, "R6 flag at top");
        ticks(1);
        chk_rd(RA_CNT, 32'd0, "R6 cleared");
        ticks(2);
        chk_rd(RA_CNT, 32'd2, "R6 restart count");

        // R7 overflow
        bus_wr(RA_FCLR, 32'h7);
        bus_wr(RA_CTRL, 32'h1);
        bus_wr(RA_CMP, 32'h100);
        bus_wr(RA_CNT, 32'hFFFF_FFFE);
        ticks(1);
        chk_rd(RA_FLAG, 32'h0, "R7 before wrap");
        ticks(1);
        chk_rd(RA_CNT, 32'h0, "R7 wrapped");
        chk_rd(RA_FLAG, 32'h1, "R7 overflow flag");

        // R8 set/clear/enable
        chk_irq(1'b0, "R8 flag masked");
        bus_wr(RA_IEN, 32'h1);
        chk_irq(1'b1, "R8 ovf enabled");
        bus_wr(RA_FSET, 32'h4);
        chk_rd(RA_FLAG, 32'h5, "R8 sw set");
        bus_wr(RA_FCLR, 32'h1);
        chk_rd(RA_FLAG, 32'h4, "R8 sw clear");
        chk_irq(1'b0, "R8 osc not enabled");
        bus_wr(RA_IEN, 32'h4);
        chk_irq(1'b1, "R8 osc enabled");
        bus_wr(RA_FCLR, 32'h4);
        chk_irq(1'b0, "R8 cleared");
        chk_rd(RA_FLAG, 32'h0, "R8 all clear");

        // R11 event beats clear
        bus_wr(RA_CMP, 32'h10);
        bus_wr(RA_CNT, 32'hF);
        bus_wr_tick(RA_FCLR, 32'h2);
        chk_rd(RA_FLAG, 32'h2, "R11 event over clear");

        // R9 lock
        bus_wr(RA_LOCK, 32'hAEE9);
        chk_rd(RA_LOCK, 32'h1, "R9 wrong key locks");
        bus_wr(RA_CTRL, 32'h0);
        bus_wr(RA_CMP, 32'h77);
        bus_wr(RA_CNT, 32'h55);
        chk_rd(RA_CTRL, 32'h1, "R9 ctrl ignored");
        chk_rd(RA_CMP, 32'h10, "R9 cmp ignored");
        chk_rd(RA_CNT, 32'h10, "R9 cnt ignored");
        ticks(2);
        chk_rd(RA_CNT, 32'h12, "R9 still counting");
        bus_wr(RA_IEN, 32'h2);
        chk_rd(RA_IEN, 32'h2, "R9 ien writable");
        bus_wr(RA_LOCK, 32'hAEE8);
        chk_rd(RA_LOCK, 32'h0, "R9 key unlocks");
        bus_wr(RA_CNT, 32'h55);
        chk_rd(RA_CNT, 32'h55, "R9 writes resume");

        // R10 freeze
        bus_wr(RA_FRZ, 32'h1);
        chk_rd(RA_FRZ, 32'h1, "R10 held");
        bus_wr(RA_CMP, 32'h40);
        chk_rd(RA_CMP, 32'h10, "R10 staged not live");
        bus_wr(RA_CMP, 32'h41);
        chk_rd(RA_CMP, 32'h10, "R10 second stage");
        bus_wr(RA_FRZ, 32'h0);
        chk_rd(RA_CMP, 32'h41, "R10 released");
        chk_rd(RA_FRZ, 32'h0, "R10 live");

        @(negedge clk);
        bus_en = 1'b0; tick_i = 1'b0;
        repeat (2) @(negedge clk);
        if (exp_q.size() != 0) begin
            n_run++;
            n_fail++;
            $display("FAIL scoreboard (all requirements): actual %0d pending expected 0", exp_q.size());
        end
        finish_run();
    end
endmodule